// File: doc/BRIEF.md
# Burst-of-Four Split-Port SRAM Core

This block is a synchronous memory with one port that only reads and one port that only writes, so the two data paths never share wires. Every access moves a whole line of four words. A single clock is used, and each rising edge carries one data beat. A command slot falls on every second edge: the first edge after reset is released, and every second edge after it.

A read request names a line address. The four words of the line come back on consecutive beats, lowest order first, after a fixed pipeline delay, and a valid flag marks them. A write request names a line address. Its four data words follow on four beats, each beat carrying its own per-byte enables, and the line is written to the array once the last beat is in. A read issued in the slot right after a write to the same line sees that write's data, merged byte by byte with the stored line. The storage is four banks, one per burst position, with a parameterised address width.

Top module: `qb_burst_sram`

## Requirements
- R1: While reset is asserted and on the edges that follow it, rd_valid is 0 and rd_data is 0. Command slots are the first rising edge after reset is released and every second edge after it.
- R2: A read accepted on slot edge t drives word k of the addressed line (k = 0..3, lowest order first) on rd_data after edge t+5+k.
- R3: A write accepted on slot edge s takes data word k from wr_data on edge s+2+k, and the line holds all four words for any read accepted at a slot of s+4 or later.
- R4: wr_be bit 0 enables the byte in wr_data[8:0] and bit 1 the byte in wr_data[17:9], sampled on the same beat as the word. A byte whose enable is 0 keeps its stored value.
- R5: A read accepted on the slot edge two edges after a write to the same line returns the new data: enabled bytes come from that write and masked bytes come from the stored line.
- R6: rd_valid is 1 on exactly the beats that carry read data, and rd_data is 0 on every other beat. A burst that is already under way completes in full when rd_sel is dropped.
- R7: A read request on the slot directly after an accepted read, or on an edge that is not a slot, is ignored and produces no beats.
- R8: A write request on the slot directly after an accepted write, or on an edge that is not a slot, is ignored. Write address, data and enables are ignored on all other edges, and an ignored write changes no stored data.
- R9: A read and a write accepted in the same slot to the same line: the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one data beat |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_sel | input | 1 | Read request, sampled on slot edges |
| rd_addr | input | ADDR_W | Line address of a read |
| rd_valid | output | 1 | High on the four beats of read data |
| rd_data | output | WORD_W | Read data word |
| wr_sel | input | 1 | Write request, sampled on slot edges |
| wr_addr | input | ADDR_W | Line address of a write |
| wr_data | input | WORD_W | Write data word for the current beat |
| wr_be | input | WORD_W/BYTE_W | Per-byte write enables for the current beat |

## Verification
The hardest case to reach is a read that lands in the one slot where its line is being committed, with a partial byte mask, while a second write has already started capturing into the same staging registers. The stimulus first fills a set of lines, then places directed write-then-read pairs with mixed masks at exact slot offsets. It then runs a long random phase over only sixteen addresses, with requests on slot and non-slot edges alike, so that forwarding, same-slot collisions and ignored back-to-back requests come up many times.

// File: rtl/qb_pkg.sv
// Package: shared constants for the burst SRAM core.
// Assumes: every access moves a fixed line of BURST words.
package qb_pkg;
    localparam int BURST = 4;
endpackage

// File: rtl/qb_bank.sv
// Module: qb_bank
// One storage bank holding a single burst position of every line.
// Write is byte-masked and synchronous. The read is combinational and,
// when a commit to the same line happens on this edge, takes the enabled
// bytes of the committing word so that the reader sees the newest data.
// Assumes: WORD_W is a whole multiple of BYTE_W.
module qb_bank #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 18,
    parameter int BYTE_W = 9
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]         wr_word,
    input  logic [WORD_W/BYTE_W-1:0]  wr_be,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [WORD_W-1:0]         rd_word
);
    localparam int LANES = WORD_W / BYTE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Byte-masked commit of one word into the bank.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_en && wr_be[l]) begin
                mem[wr_addr][l*BYTE_W +: BYTE_W] <= wr_word[l*BYTE_W +: BYTE_W];
            end
        end
    end

    // Array read with byte-wise bypass of a commit to the same line.
    always_comb begin
        rd_word = mem[rd_addr];
        for (int l = 0; l < LANES; l++) begin
            if (wr_en && wr_be[l] && (wr_addr == rd_addr)) begin
                rd_word[l*BYTE_W +: BYTE_W] = wr_word[l*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/qb_wr_port.sv
// Module: qb_wr_port
// Accepts write requests on slot edges, captures four data beats with
// their byte enables and raises a one-cycle commit after the last beat.
// A request in the slot right after an accepted one is dropped, so at most
// two writes overlap: the staging registers are refilled beat by beat only
// after the older write has read them.
// Assumes: slot is high in the cycle before each command-slot edge.
module qb_wr_port
    import qb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 18,
    parameter int BYTE_W = 9
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  slot,
    input  logic                                  wr_sel,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [WORD_W-1:0]                     wr_data,
    input  logic [WORD_W/BYTE_W-1:0]              wr_be,
    output logic                                  commit_en,
    output logic [ADDR_W-1:0]                     commit_addr,
    output logic [BURST-1:0][WORD_W-1:0]          commit_data,
    output logic [BURST-1:0][WORD_W/BYTE_W-1:0]   commit_be
);
    localparam int LANES = WORD_W / BYTE_W;
    localparam int STAGES = BURST + 2;

    logic [STAGES-1:0] wsh;
    logic              acc;
    logic [ADDR_W-1:0] pend_addr;

    assign acc       = slot && wr_sel && !wsh[1];
    assign commit_en = wsh[STAGES-1];

    // Age of each accepted write, one bit per elapsed edge.
    always_ff @(posedge clk) begin
        if (!rst_n) wsh <= '0;
        else        wsh <= {wsh[STAGES-2:0], acc};
    end

    // Address hand-off: held at accept, moved to commit before the next accept.
    always_ff @(posedge clk) begin
        if (acc)    pend_addr   <= wr_addr;
        if (wsh[1]) commit_addr <= pend_addr;
    end

    // Beat capture: word k and its enables land on edge s+2+k.
    always_ff @(posedge clk) begin
        for (int k = 0; k < BURST; k++) begin
            if (wsh[1+k]) begin
                commit_data[k] <= wr_data;
                commit_be[k]   <= wr_be;
            end
        end
    end

    // R8: no two accepted writes in adjacent slots.
    assert_no_b2b_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##2 !acc);

    // R3: the first data beat is taken on a command-slot edge.
    assert_beat0_on_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wsh[1] |-> slot);

    // R3: a commit is only ever raised after a full capture window.
    assert_commit_follows_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit_en) |-> $past(wsh[BURST], 1));
endmodule

// File: rtl/qb_rd_port.sv
// Module: qb_rd_port
// Accepts read requests on slot edges, fetches the merged line four edges
// later and plays it out one word per beat, lowest order first.
// Assumes: slot is high in the cycle before each command-slot edge and
// line_in is valid combinationally for fetch_addr.
module qb_rd_port
    import qb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 18
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          slot,
    input  logic                          rd_sel,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [ADDR_W-1:0]             fetch_addr,
    input  logic [BURST-1:0][WORD_W-1:0]  line_in,
    output logic                          rd_valid,
    output logic [WORD_W-1:0]             rd_data
);
    localparam int FETCH  = 3;
    localparam int STAGES = FETCH + 1 + BURST;

    logic [STAGES-1:0]            rsh;
    logic                         acc;
    logic                         fetch_en;
    logic [BURST-1:0][WORD_W-1:0] rline;

    assign acc      = slot && rd_sel && !rsh[1];
    assign fetch_en = rsh[FETCH];

    // Age of each accepted read, one bit per elapsed edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rsh <= '0;
        else        rsh <= {rsh[STAGES-2:0], acc};
    end

    // Address capture and line fetch.
    always_ff @(posedge clk) begin
        if (acc)      fetch_addr <= rd_addr;
        if (fetch_en) rline      <= line_in;
    end

    // Output beat: word k on the edge after stage FETCH+1+k is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= |rsh[STAGES-1:FETCH+1];
            rd_data  <= '0;
            for (int k = 0; k < BURST; k++) begin
                if (rsh[FETCH+1+k]) rd_data <= rline[k];
            end
        end
    end

    // R6: once valid rises it stays for a full burst.
    assert_valid_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid ##1 rd_valid ##1 rd_valid);

    // R2: data starts two edges after the line fetch.
    assert_fetch_before_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(fetch_en, 2));

    // R7: no two accepted reads in adjacent slots.
    assert_no_b2b_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##2 !acc);
endmodule

// File: rtl/qb_burst_sram.sv
// Module: qb_burst_sram (top)
// Split-port burst-of-four SRAM: a slot phase toggle, a write port, a read
// port and one bank per burst position. The fetch of a read and the commit
// of a write from the previous slot fall on the same edge; the banks'
// bypass covers that case.
// Assumes: a single clock where each edge is one data beat.
module qb_burst_sram
    import qb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 18,
    parameter int BYTE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_sel,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic                      rd_valid,
    output logic [WORD_W-1:0]         rd_data,
    input  logic                      wr_sel,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic [WORD_W/BYTE_W-1:0]  wr_be
);
    localparam int LANES = WORD_W / BYTE_W;

    logic                               phase;
    logic                               slot;
    logic                               commit_en;
    logic [ADDR_W-1:0]                  commit_addr;
    logic [BURST-1:0][WORD_W-1:0]       commit_data;
    logic [BURST-1:0][LANES-1:0]        commit_be;
    logic [ADDR_W-1:0]                  fetch_addr;
    logic [BURST-1:0][WORD_W-1:0]       line;

    // Slot phase: the first edge after reset is a command slot.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end
    assign slot = ~phase;

    qb_wr_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .slot(slot),
        .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .commit_en(commit_en), .commit_addr(commit_addr),
        .commit_data(commit_data), .commit_be(commit_be)
    );

    qb_rd_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .slot(slot),
        .rd_sel(rd_sel), .rd_addr(rd_addr),
        .fetch_addr(fetch_addr), .line_in(line),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // One bank per burst position.
    for (genvar b = 0; b < BURST; b++) begin : g_bank
        qb_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_bank (
            .clk(clk), .wr_en(commit_en), .wr_addr(commit_addr),
            .wr_word(commit_data[b]), .wr_be(commit_be[b]),
            .rd_addr(fetch_addr), .rd_word(line[b])
        );
    end

    // R1: no read data appears in the first edges after reset.
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rd_valid);
endmodule

// File: tb/tb_qb_burst_sram.sv
module tb_qb_burst_sram;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int WORD_W = 18;
    localparam int NS     = 2400;
    localparam int NE     = NS + 16;
    localparam int D      = 136;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_sel = 1'b0, wr_sel = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0, wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [1:0] wr_be = '0;
    logic rd_valid;
    logic [WORD_W-1:0] rd_data;

    qb_burst_sram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(9)) dut (
        .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
    );

    always #(CLK_P/2) clk = ~clk;

    bit rs[NE], ws[NE], ev[NE];
    logic [ADDR_W-1:0] ra[NE], wa[NE];
    logic [WORD_W-1:0] wd[NE], ed[NE];
    logic [1:0] wb[NE];
    string stag[NE], dt[NE], vt[NE];
    logic [WORD_W-1:0] mdl[256][4];
    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic chk(bit ok, string tag, string what, int e, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s edge=%0d act=%0h exp=%0h", tag, what, e, act, exp);
        end
    endtask

    // Byte-masked merge of one beat into a stored word (R4).
    function automatic logic [WORD_W-1:0] merge(logic [WORD_W-1:0] old, logic [WORD_W-1:0] nw, logic [1:0] be);
        logic [WORD_W-1:0] r;
        r = old;
        if (be[0]) r[8:0]  = nw[8:0];
        if (be[1]) r[17:9] = nw[17:9];
        return r;
    endfunction

    // Transaction-level expected outputs, built from the requirements.
    task automatic build_expected();
        int rlast = -100, wlast = -100;
        logic [ADDR_W-1:0] wlast_a = '0;
        for (int e = 0; e < NS; e += 2) begin
            bit wacc;
            wacc = ws[e] && (e - wlast != 2);
            if (rs[e]) begin
                if (e - rlast == 2) begin
                    vt[e+7] = "R7"; vt[e+8] = "R7";
                end else begin
                    string tg;
                    rlast = e;
                    tg = stag[e];
                    if (wacc && wa[e] == ra[e]) tg = "R9";
                    if (wlast == e - 2 && wlast_a == ra[e]) tg = "R5";
                    for (int k = 0; k < 4; k++) begin
                        ev[e+5+k] = 1'b1;
                        ed[e+5+k] = mdl[ra[e]][k];
                        dt[e+5+k] = tg;
                        vt[e+5+k] = "R6";
                    end
                end
            end
            if (wacc) begin
                wlast = e; wlast_a = wa[e];
                for (int k = 0; k < 4; k++)
                    mdl[wa[e]][k] = merge(mdl[wa[e]][k], wd[e+2+k], wb[e+2+k]);
            end
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R2 watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int e = 0; e < NE; e++) begin
            rs[e] = 0; ws[e] = 0; ev[e] = 0; ra[e] = '0; wa[e] = '0;
            wd[e] = '0; wb[e] = '0; ed[e] = '0;
            stag[e] = "R2"; dt[e] = "R6"; vt[e] = "R6";
        end
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < 4; k++) mdl[a][k] = '0;
        // Prefill lines 0..15 with full-enable writes.
        for (int i = 0; i < 16; i++) begin
            ws[8*i] = 1; wa[8*i] = ADDR_W'(i);
            for (int k = 0; k < 4; k++) begin
                wd[8*i+2+k] = WORD_W'($urandom); wb[8*i+2+k] = 2'b11;
            end
        end
        // Directed: partial-mask write then forward read in next slot (R4, R5).
        ws[D] = 1; wa[D] = 3;
        for (int k = 0; k < 4; k++) wd[D+2+k] = WORD_W'($urandom);
        wb[D+2] = 2'b01; wb[D+3] = 2'b10; wb[D+4] = 2'b00; wb[D+5] = 2'b11;
        rs[D+2] = 1; ra[D+2] = 3;
        // Back-to-back write is ignored (R8), back-to-back read ignored (R7).
        ws[D+2] = 1; wa[D+2] = 3;
        wd[D+6] = WORD_W'($urandom); wb[D+6] = 2'b11;
        wd[D+7] = WORD_W'($urandom); wb[D+7] = 2'b11;
        rs[D+4] = 1; ra[D+4] = 5;
        rs[D+8] = 1; ra[D+8] = 3; stag[D+8] = "R8";
        // Same-slot read and write of one line (R9), later read (R3).
        ws[D+12] = 1; wa[D+12] = 4; rs[D+12] = 1; ra[D+12] = 4;
        for (int k = 0; k < 4; k++) begin
            wd[D+14+k] = WORD_W'($urandom); wb[D+14+k] = 2'b11;
        end
        rs[D+16] = 1; ra[D+16] = 4; stag[D+16] = "R3";
        rs[D+24] = 1; ra[D+24] = 3; stag[D+24] = "R4";
        // Random phase on sixteen lines, requests on any edge.
        for (int e = D + 32; e < NS; e++) begin
            rs[e] = ($urandom % 5) < 2; ws[e] = ($urandom % 5) < 2;
            ra[e] = ADDR_W'($urandom % 16); wa[e] = ADDR_W'($urandom % 16);
            wd[e] = WORD_W'($urandom); wb[e] = 2'($urandom % 4);
        end
        build_expected();

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(rd_valid === 1'b0, "R1", "reset valid", -1, 32'(rd_valid), 0);
        chk(rd_data === '0, "R1", "reset data", -1, 32'(rd_data), 0);
        rst_n = 1'b1;
        for (int e = 0; e < NE; e++) begin
            rd_sel = rs[e]; rd_addr = ra[e];
            wr_sel = ws[e]; wr_addr = wa[e];
            wr_data = wd[e]; wr_be = wb[e];
            @(posedge clk);
            @(negedge clk);
            chk(rd_valid === ev[e], vt[e], "valid", e, 32'(rd_valid), 32'(ev[e]));
            chk(rd_data === ed[e], ev[e] ? dt[e] : "R6", "data", e, 32'(rd_data), 32'(ed[e]));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule